// File: doc/BRIEF.md
# CAN controller status and interrupt unit

This unit keeps the control-side state of a byte-addressed CAN controller: the mode register, the status register, the latched interrupt causes, the interrupt mask and a clock-divider register. The transmit path and the receive buffer report what happens to them through single-cycle event pulses. The unit turns those pulses into status bits and interrupt causes, and it drives one level-sensitive interrupt line towards the host.

The host reaches the registers through a simple byte read/write port. Read data is combinational from the registered state. A read of the interrupt-flag register also clears the flags at the next clock edge. A write to the command register can start a transmission, release a received message or clear an overrun. The first two appear as one-cycle pulses for the neighbouring logic to act on.

There are two reset sources. An active-low hardware reset loads a fixed power-up pattern. A synchronous software reset pulse forces selected mode and status bits and leaves the interrupt flags and mask as they are.

Top module: `can_status_irq`

## Requirements
- R1: While `rst_n` is low and after it rises, the registers read as follows with no writes in between: mode 0x01, status 0x3C, flags 0x00, enable mask 0x00, clock divider 0x00. `irq` is low.
- R2: A `sw_rst` pulse changes the mode register by clearing bits 5, 4 and 0 and then setting bit 0. It changes status by clearing bits 5, 4, 2, 1 and 0 and then setting bits 5, 4 and 2. Flags and enable mask keep their values. Events and register writes in the same cycle have no effect.
- R3: `irq` is high exactly when the enable mask (address 4) and the flag register (address 3) share a set bit, both taken from their registered values.
- R4: Reading address 3 returns the flags as they are, and the flags become 0 at the next edge. If `rx_pending` is high during the read, flag bit 0 (receive) is set again at once.
- R5: Writing address 1 with bit 0 set pulses `tx_go` in the same cycle and clears status bits 2 and 3. `ev_tx_done` sets status bits 2 (buffer free) and 3 (complete), clears status bit 5 (transmitting) and sets flag bit 1.
- R6: Any write to address 16 (first transmit frame byte) sets status bit 5.
- R7: `ev_rx_start` sets status bit 4 and `ev_rx_end` clears it. `ev_msg_stored` sets status bit 0 and flag bit 0. `ev_buf_empty` clears both of those bits.
- R8: `ev_overrun` sets status bit 1 and flag bit 3. Writing address 1 with bit 3 set clears both. Writing address 1 with bit 2 set pulses `rx_release` in the same cycle.
- R9: Address 1 always reads 0x00. Writes to address 2 (status) and address 3 (flags) change nothing.
- R10: A write to address 0 stores only the low five bits; bits 7 to 5 read as 0. `mode_o` shows the stored mode.
- R11: When a bit is set and cleared in the same cycle, whether by an event, a command or a flag read, the bit ends up set.
- R12: Addresses 4 and 31 read back the last value written to them. Addresses with no register read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| sw_rst | input | 1 | Software reset pulse, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| ev_tx_done | input | 1 | Transmission finished |
| ev_rx_start | input | 1 | Frame reception began |
| ev_rx_end | input | 1 | Frame stored, rejected or dropped |
| ev_msg_stored | input | 1 | Message entered the receive buffer |
| ev_buf_empty | input | 1 | Receive buffer became empty |
| ev_overrun | input | 1 | Receive buffer overran |
| rx_pending | input | 1 | Receive message count is nonzero |
| tx_go | output | 1 | Transmit request pulse |
| rx_release | output | 1 | Release-message pulse |
| mode_o | output | 8 | Current mode register |
| irq | output | 1 | Level interrupt line |

## Verification
The bench goes after four corner cases. The first is a flag read while messages are still pending: a design that cleared unconditionally would drop the receive interrupt even though data is waiting. The second is collisions, where an event pulse meets its clear command or a flag read in the same cycle: a design that let the clear win would lose an overrun or a transmit-complete cause. The third is a software reset landing together with an event: a wrong design would either corrupt the forced status pattern or wipe the flags, which must survive. The last is writes to the read-only status, flag and command locations, together with the five-bit mode mask: a design that stored these writes would read back the written value.

// File: rtl/can_si_pkg.sv
package can_si_pkg;

    localparam int BYTE_W = 8;

    // status bit positions
    localparam int ST_RXBUF  = 0;
    localparam int ST_OVR    = 1;
    localparam int ST_TXFREE = 2;
    localparam int ST_TXDONE = 3;
    localparam int ST_RXING  = 4;
    localparam int ST_TXING  = 5;

    // interrupt flag bit positions
    localparam int IF_RX  = 0;
    localparam int IF_TX  = 1;
    localparam int IF_OVR = 3;

    // command masks
    localparam logic [BYTE_W-1:0] CMD_TX_M  = 8'h01;
    localparam logic [BYTE_W-1:0] CMD_REL_M = 8'h04;
    localparam logic [BYTE_W-1:0] CMD_CLR_M = 8'h08;

    // reset patterns
    localparam logic [BYTE_W-1:0] HW_MODE     = 8'h01;
    localparam logic [BYTE_W-1:0] HW_STAT     = 8'h3C;
    localparam logic [BYTE_W-1:0] SW_MODE_CLR = 8'h31;
    localparam logic [BYTE_W-1:0] SW_MODE_SET = 8'h01;
    localparam logic [BYTE_W-1:0] SW_STAT_CLR = 8'h37;
    localparam logic [BYTE_W-1:0] SW_STAT_SET = 8'h34;
    localparam logic [BYTE_W-1:0] MODE_KEEP   = 8'h1F;

    typedef struct packed {
        logic [BYTE_W-1:0] mode;
        logic [BYTE_W-1:0] status;
        logic [BYTE_W-1:0] flags;
        logic [BYTE_W-1:0] ien;
        logic [BYTE_W-1:0] clkdiv;
    } regs_t;

    typedef struct packed {
        logic wr_mode;
        logic wr_ien;
        logic wr_clk;
        logic wr_txfirst;
        logic cmd_tx;
        logic cmd_rel;
        logic cmd_clrovr;
        logic rd_flags;
    } dec_t;

    typedef struct packed {
        logic tx_done;
        logic rx_start;
        logic rx_end;
        logic msg_stored;
        logic buf_empty;
        logic overrun;
    } evt_t;

endpackage

// File: rtl/can_si_decode.sv
module can_si_decode
    import can_si_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int A_MODE = 0,
    parameter int A_CMD  = 1,
    parameter int A_IEN  = 4,
    parameter int A_FLAG = 3,
    parameter int A_TXF  = 16,
    parameter int A_CLK  = 31
) (
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output dec_t              dec
);
    logic cmd_hit;

    always_comb begin
        cmd_hit        = reg_wr && (reg_addr == ADDR_W'(A_CMD));
        dec.wr_mode    = reg_wr && (reg_addr == ADDR_W'(A_MODE));
        dec.wr_ien     = reg_wr && (reg_addr == ADDR_W'(A_IEN));
        dec.wr_clk     = reg_wr && (reg_addr == ADDR_W'(A_CLK));
        dec.wr_txfirst = reg_wr && (reg_addr == ADDR_W'(A_TXF));
        dec.cmd_tx     = cmd_hit && ((reg_wdata & CMD_TX_M) != '0);
        dec.cmd_rel    = cmd_hit && ((reg_wdata & CMD_REL_M) != '0);
        dec.cmd_clrovr = cmd_hit && ((reg_wdata & CMD_CLR_M) != '0);
        dec.rd_flags   = reg_rd && (reg_addr == ADDR_W'(A_FLAG));
    end

endmodule

// File: rtl/can_si_regs.sv
module can_si_regs
    import can_si_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  dec_t              dec,
    input  logic [BYTE_W-1:0] wdata,
    input  evt_t              ev,
    input  logic              rx_pending,
    output regs_t             regs_q
);
    regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (sw_rst) begin
            regs_d.mode   = (regs_q.mode & ~SW_MODE_CLR) | SW_MODE_SET;
            regs_d.status = (regs_q.status & ~SW_STAT_CLR) | SW_STAT_SET;
        end else begin
            if (dec.wr_mode) regs_d.mode   = wdata & MODE_KEEP;
            if (dec.wr_ien)  regs_d.ien    = wdata;
            if (dec.wr_clk)  regs_d.clkdiv = wdata;

            // clearing sources first
            if (dec.cmd_tx) begin
                regs_d.status[ST_TXFREE] = 1'b0;
                regs_d.status[ST_TXDONE] = 1'b0;
            end
            if (ev.tx_done) regs_d.status[ST_TXING] = 1'b0;
            if (ev.rx_end)  regs_d.status[ST_RXING] = 1'b0;
            if (ev.buf_empty) begin
                regs_d.status[ST_RXBUF] = 1'b0;
                regs_d.flags[IF_RX]     = 1'b0;
            end
            if (dec.cmd_clrovr) begin
                regs_d.status[ST_OVR] = 1'b0;
                regs_d.flags[IF_OVR]  = 1'b0;
            end
            if (dec.rd_flags) begin
                regs_d.flags = '0;
                if (rx_pending) regs_d.flags[IF_RX] = 1'b1;
            end

            // setting sources last so that a set wins
            if (ev.tx_done) begin
                regs_d.status[ST_TXFREE] = 1'b1;
                regs_d.status[ST_TXDONE] = 1'b1;
                regs_d.flags[IF_TX]      = 1'b1;
            end
            if (dec.wr_txfirst) regs_d.status[ST_TXING] = 1'b1;
            if (ev.rx_start)    regs_d.status[ST_RXING] = 1'b1;
            if (ev.msg_stored) begin
                regs_d.status[ST_RXBUF] = 1'b1;
                regs_d.flags[IF_RX]     = 1'b1;
            end
            if (ev.overrun) begin
                regs_d.status[ST_OVR] = 1'b1;
                regs_d.flags[IF_OVR]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.mode   <= HW_MODE;
            regs_q.status <= HW_STAT;
            regs_q.flags  <= '0;
            regs_q.ien    <= '0;
            regs_q.clkdiv <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

endmodule

// File: rtl/can_si_rdmux.sv
module can_si_rdmux
    import can_si_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int A_MODE = 0,
    parameter int A_STAT = 2,
    parameter int A_FLAG = 3,
    parameter int A_IEN  = 4,
    parameter int A_CLK  = 31
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  regs_t             regs,
    output logic [BYTE_W-1:0] rdata
);
    always_comb begin
        case (reg_addr)
            ADDR_W'(A_MODE): rdata = regs.mode;
            ADDR_W'(A_STAT): rdata = regs.status;
            ADDR_W'(A_FLAG): rdata = regs.flags;
            ADDR_W'(A_IEN):  rdata = regs.ien;
            ADDR_W'(A_CLK):  rdata = regs.clkdiv;
            default:         rdata = '0;
        endcase
    end

endmodule

// File: rtl/can_status_irq.sv
module can_status_irq
    import can_si_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int A_MODE = 0,
    parameter int A_CMD  = 1,
    parameter int A_STAT = 2,
    parameter int A_FLAG = 3,
    parameter int A_IEN  = 4,
    parameter int A_TXF  = 16,
    parameter int A_CLK  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              ev_tx_done,
    input  logic              ev_rx_start,
    input  logic              ev_rx_end,
    input  logic              ev_msg_stored,
    input  logic              ev_buf_empty,
    input  logic              ev_overrun,
    input  logic              rx_pending,
    output logic              tx_go,
    output logic              rx_release,
    output logic [7:0]        mode_o,
    output logic              irq
);
    dec_t  dec;
    evt_t  ev;
    regs_t regs_q;

    always_comb begin
        ev.tx_done    = ev_tx_done;
        ev.rx_start   = ev_rx_start;
        ev.rx_end     = ev_rx_end;
        ev.msg_stored = ev_msg_stored;
        ev.buf_empty  = ev_buf_empty;
        ev.overrun    = ev_overrun;
    end

    can_si_decode #(
        .ADDR_W(ADDR_W), .A_MODE(A_MODE), .A_CMD(A_CMD), .A_IEN(A_IEN),
        .A_FLAG(A_FLAG), .A_TXF(A_TXF), .A_CLK(A_CLK)
    ) u_dec (
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .dec       (dec)
    );

    can_si_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_rst     (sw_rst),
        .dec        (dec),
        .wdata      (reg_wdata),
        .ev         (ev),
        .rx_pending (rx_pending),
        .regs_q     (regs_q)
    );

    can_si_rdmux #(
        .ADDR_W(ADDR_W), .A_MODE(A_MODE), .A_STAT(A_STAT), .A_FLAG(A_FLAG),
        .A_IEN(A_IEN), .A_CLK(A_CLK)
    ) u_rd (
        .reg_addr (reg_addr),
        .regs     (regs_q),
        .rdata    (reg_rdata)
    );

    always_comb begin
        irq        = |(regs_q.flags & regs_q.ien);
        tx_go      = dec.cmd_tx;
        rx_release = dec.cmd_rel;
        mode_o     = regs_q.mode;
    end

endmodule

// File: rtl/can_si_checker.sv
module can_si_checker #(
    parameter int ADDR_W = 5,
    parameter int A_MODE = 0,
    parameter int A_CMD  = 1,
    parameter int A_FLAG = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_rst,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_rdata,
    input logic              ev_tx_done,
    input logic              ev_msg_stored,
    input logic              ev_overrun,
    input logic              rx_pending,
    input logic              irq,
    input logic [7:0]        mode_o,
    input logic [7:0]        status,
    input logic [7:0]        flags,
    input logic [7:0]        ien
);
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 8'h00) |-> !irq); // R3

    AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(A_CMD)) |-> (reg_rdata == 8'h00)); // R9

    AST_FLAG_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(A_FLAG) && !rx_pending && !sw_rst &&
         !ev_tx_done && !ev_msg_stored && !ev_overrun) |=> (flags == 8'h00)); // R4

    AST_TX_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx_done && !sw_rst) |=> ((status & 8'h0C) == 8'h0C) && ((flags & 8'h02) != 0)); // R5

    AST_OVERRUN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_overrun && !sw_rst) |=> ((status & 8'h02) != 0) && ((flags & 8'h08) != 0)); // R11

    AST_MODE_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(A_MODE) && !sw_rst) |=> ((mode_o & 8'hE0) == 8'h00)); // R10

    AST_SWRST_MODE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> ((mode_o & 8'h01) != 0)); // R2

endmodule

bind can_status_irq can_si_checker #(
    .ADDR_W(ADDR_W), .A_MODE(A_MODE), .A_CMD(A_CMD), .A_FLAG(A_FLAG)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_rst        (sw_rst),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_addr      (reg_addr),
    .reg_rdata     (reg_rdata),
    .ev_tx_done    (ev_tx_done),
    .ev_msg_stored (ev_msg_stored),
    .ev_overrun    (ev_overrun),
    .rx_pending    (rx_pending),
    .irq           (irq),
    .mode_o        (mode_o),
    .status        (regs_q.status),
    .flags         (regs_q.flags),
    .ien           (regs_q.ien)
);

// File: tb/sim_can_status_irq.sv
module sim_can_status_irq;
    logic       clk = 1'b0;
    logic       rst_n, sw_rst, reg_wr, reg_rd;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata, mode_o;
    logic       ev_tx_done, ev_rx_start, ev_rx_end, ev_msg_stored, ev_buf_empty, ev_overrun;
    logic       rx_pending, tx_go, rx_release, irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    can_status_irq u0 (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_tx_done(ev_tx_done), .ev_rx_start(ev_rx_start), .ev_rx_end(ev_rx_end),
        .ev_msg_stored(ev_msg_stored), .ev_buf_empty(ev_buf_empty), .ev_overrun(ev_overrun),
        .rx_pending(rx_pending), .tx_go(tx_go), .rx_release(rx_release),
        .mode_o(mode_o), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    // driver: pushes the expected read value, monitor compares it
    task automatic rd(input logic [4:0] a, input logic [7:0] e, input string tag);
        reg_rd = 1'b1; reg_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        cyc();
        reg_rd = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (reg_rd && rst_n) begin
            if (exp_q.size() == 0) begin
                chk("monitor-underflow", 8'h01, 8'h00);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, reg_rdata, e);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sw_rst = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
        reg_addr = '0; reg_wdata = '0; rx_pending = 1'b0;
        ev_tx_done = 1'b0; ev_rx_start = 1'b0; ev_rx_end = 1'b0;
        ev_msg_stored = 1'b0; ev_buf_empty = 1'b0; ev_overrun = 1'b0;
        cyc(); cyc();
        chk("R1 irq in reset", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        cyc();

        // R1 power-up values
        rd(5'd0, 8'h01, "R1 mode");
        rd(5'd2, 8'h3C, "R1 status");
        rd(5'd3, 8'h00, "R1 flags");
        rd(5'd4, 8'h00, "R1 enable");
        rd(5'd31, 8'h00, "R1 clkdiv");
        chk("R1 mode_o", mode_o, 8'h01);

        // R12 plain registers and holes
        wr(5'd31, 8'h80);
        rd(5'd31, 8'h80, "R12 clkdiv readback");
        rd(5'd7, 8'h00, "R12 unmapped");

        // R10 mode mask
        wr(5'd0, 8'hFE);
        rd(5'd0, 8'h1E, "R10 mode masked");
        chk("R10 mode_o", mode_o, 8'h1E);
        wr(5'd0, 8'h08);

        // R9 read-only locations
        wr(5'd2, 8'h00);
        rd(5'd2, 8'h3C, "R9 status write ignored");
        wr(5'd3, 8'hFF);
        rd(5'd3, 8'h00, "R9 flag write ignored");
        rd(5'd1, 8'h00, "R9 command reads zero");

        wr(5'd4, 8'h0B);
        rd(5'd4, 8'h0B, "R12 enable readback");

        // R5 transmit request and completion
        reg_wr = 1'b1; reg_addr = 5'd1; reg_wdata = 8'h01;
        #1;
        chk("R5 tx_go", {7'b0, tx_go}, 8'h01);
        cyc();
        reg_wr = 1'b0;
        rd(5'd2, 8'h30, "R5 status after request");
        ev_tx_done = 1'b1; cyc(); ev_tx_done = 1'b0;
        chk("R3 irq on tx flag", {7'b0, irq}, 8'h01);
        rd(5'd2, 8'h1C, "R5 status after done");

        // R4 read clears
        rd(5'd3, 8'h02, "R4 flag read value");
        chk("R4 irq after read", {7'b0, irq}, 8'h00);
        rd(5'd3, 8'h00, "R4 flags cleared");

        // R6 first transmit byte
        wr(5'd16, 8'h55);
        rd(5'd2, 8'h3C, "R6 transmitting set");

        // R7 receive events
        ev_rx_end = 1'b1; cyc(); ev_rx_end = 1'b0;
        rd(5'd2, 8'h2C, "R7 receiving cleared");
        ev_rx_start = 1'b1; cyc(); ev_rx_start = 1'b0;
        rd(5'd2, 8'h3C, "R7 receiving set");
        ev_rx_end = 1'b1; cyc(); ev_rx_end = 1'b0;
        rx_pending = 1'b1;
        ev_msg_stored = 1'b1; cyc(); ev_msg_stored = 1'b0;
        chk("R7 irq on stored", {7'b0, irq}, 8'h01);
        rd(5'd3, 8'h01, "R4 receive flag read");
        rd(5'd3, 8'h01, "R4 receive flag re-set while pending");
        rx_pending = 1'b0;
        ev_buf_empty = 1'b1; cyc(); ev_buf_empty = 1'b0;
        chk("R7 irq after empty", {7'b0, irq}, 8'h00);
        rd(5'd2, 8'h2C, "R7 buffer status cleared");
        rd(5'd3, 8'h00, "R7 receive flag cleared");

        // R8 overrun and commands
        ev_overrun = 1'b1; cyc(); ev_overrun = 1'b0;
        chk("R8 irq on overrun", {7'b0, irq}, 8'h01);
        rd(5'd2, 8'h2E, "R8 overrun status");
        wr(5'd1, 8'h08);
        chk("R8 irq after clear", {7'b0, irq}, 8'h00);
        rd(5'd2, 8'h2C, "R8 overrun cleared");
        reg_wr = 1'b1; reg_addr = 5'd1; reg_wdata = 8'h04;
        #1;
        chk("R8 rx_release", {7'b0, rx_release}, 8'h01);
        chk("R8 no tx_go on release", {7'b0, tx_go}, 8'h00);
        cyc();
        reg_wr = 1'b0;

        // R11 set wins
        ev_overrun = 1'b1; reg_wr = 1'b1; reg_addr = 5'd1; reg_wdata = 8'h08;
        cyc();
        ev_overrun = 1'b0; reg_wr = 1'b0;
        rd(5'd2, 8'h2E, "R11 overrun beats clear");
        chk("R11 irq kept", {7'b0, irq}, 8'h01);
        wr(5'd1, 8'h08);
        ev_tx_done = 1'b1;
        rd(5'd3, 8'h00, "R11 read during tx done");
        ev_tx_done = 1'b0;
        rd(5'd3, 8'h02, "R11 tx flag beats read clear");
        rd(5'd2, 8'h0C, "R5 transmitting cleared");
        ev_msg_stored = 1'b1; ev_buf_empty = 1'b1; cyc();
        ev_msg_stored = 1'b0; ev_buf_empty = 1'b0;
        rd(5'd2, 8'h0D, "R11 stored beats empty");
        rd(5'd3, 8'h01, "R11 receive flag kept");
        ev_buf_empty = 1'b1; cyc(); ev_buf_empty = 1'b0;

        // R3 masking
        wr(5'd4, 8'h00);
        ev_overrun = 1'b1; cyc(); ev_overrun = 1'b0;
        chk("R3 masked cause", {7'b0, irq}, 8'h00);
        wr(5'd4, 8'h08);
        chk("R3 unmasked cause", {7'b0, irq}, 8'h01);

        // R2 software reset with a colliding event
        wr(5'd0, 8'h1F);
        sw_rst = 1'b1; ev_msg_stored = 1'b1; cyc();
        sw_rst = 1'b0; ev_msg_stored = 1'b0;
        rd(5'd0, 8'h0F, "R2 mode after soft reset");
        rd(5'd2, 8'h3C, "R2 status after soft reset");
        chk("R2 irq survives soft reset", {7'b0, irq}, 8'h01);
        rd(5'd3, 8'h08, "R2 flags kept");

        // R1 hardware reset mid-run
        wr(5'd4, 8'hFF);
        rst_n = 1'b0; cyc(); cyc();
        rst_n = 1'b1; cyc();
        rd(5'd0, 8'h01, "R1 mode after reset");
        rd(5'd4, 8'h00, "R1 enable after reset");
        rd(5'd31, 8'h00, "R1 clkdiv after reset");
        rd(5'd2, 8'h3C, "R1 status after reset");

        cyc(); cyc();
        if (exp_q.size() != 0) chk("monitor-leftover", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule